// File: doc/BRIEF.md
# Selectable Baud-Rate Clock Output

This block drives a clock output pin for a modem data pump. The pin carries one of two clocks. The first is the crystal clock itself, passed straight through. The second is a divided clock that runs at sixteen times the current data rate. A control bit requests the divided clock, and the modulation-kind and modulation-option fields set the division ratio. The divided clock is only produced for the phase-modulated kinds (differential phase shift keying and quadrature amplitude modulation). For frequency shift keying, when the control bit is clear, and after either reset, the pin carries the crystal clock.

With the default 11.0592 MHz crystal, the divided output runs at 38400 Hz for 2400 bit/s, 19200 Hz for 1200 bit/s and 9600 Hz for 600 bit/s, each with an even duty cycle. Changes of source or ratio are deferred to the end of a low phase of the divided clock. The crystal path is opened and closed by a gate that changes only while the crystal is low, so the pin never shows a pulse shorter than half a crystal period.

Top module: `baud_clk_sel`

## Requirements
- R1: While the hardware reset `rst_i` or the software reset `soft_rst_i` is high, the divider is forced idle at the next crystal edge and the output follows the crystal clock (period of one crystal cycle).
- R2: With `clk_sel_i` low, the output is the crystal clock, whatever the modulation fields hold.
- R3: With `mod_kind_i` equal to 2'b10 or 2'b11 (frequency shift keying), the output stays the crystal clock even when `clk_sel_i` is high.
- R4: With `clk_sel_i` high and `mod_kind_i` = 2'b01 (quadrature amplitude), the output period is DIV_2400 (288) crystal cycles, and `mod_opt_i` has no effect.
- R5: With `clk_sel_i` high, `mod_kind_i` = 2'b00 (differential phase) and `mod_opt_i` = 0, the output period is DIV_1200 (576) crystal cycles.
- R6: With `clk_sel_i` high, `mod_kind_i` = 2'b00 and `mod_opt_i` = 1, the output period is DIV_600 (1152) crystal cycles.
- R7: The divided output is high for exactly half of its period.
- R8: A change of ratio or source made while the divided clock runs takes effect only at the end of a low phase. The period in progress completes at the old ratio, and when returning to the crystal, the first crystal rising edge on the output comes one crystal cycle after that boundary.
- R9: No high or low pulse on the output is shorter than half a crystal period, across every switch and reset. The divided-clock register stays low whenever the crystal path is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Crystal clock |
| rst_i | input | 1 | Hardware reset, synchronous, active high |
| soft_rst_i | input | 1 | Software reset request, synchronous, active high |
| clk_sel_i | input | 1 | 0 = crystal on the pin, 1 = sixteen times the data rate |
| mod_kind_i | input | 2 | 00 differential phase, 01 quadrature amplitude, 1x frequency shift |
| mod_opt_i | input | 1 | Differential phase rate: 0 = 1200 bit/s, 1 = 600 bit/s |
| clk_o | output | 1 | Selected output clock |

## Verification
The output is measured edge to edge for each of the three divided ratios. This separates the ratio decode and shows the even duty cycle. Frequency shift keying with the select bit set, the select bit cleared under a phase mode, and quadrature amplitude with the option bit set each isolate one gating term of the decode. A ratio change placed mid-high phase and a return to the crystal placed mid-high phase show that switching is deferred to the low-phase boundary. A pulse-width monitor running over the whole sequence, which includes a software reset taken while dividing, catches any runt pulse at a switch.

// File: rtl/baud_clk_pkg.sv
package baud_clk_pkg;

  typedef enum logic [1:0] {
    MK_DPSK  = 2'b00,
    MK_QAM   = 2'b01,
    MK_FSK_A = 2'b10,
    MK_FSK_B = 2'b11
  } mod_kind_e;

  function automatic logic is_phase_mod(input logic [1:0] kind);
    return (kind == MK_DPSK) || (kind == MK_QAM);
  endfunction

endpackage

// File: rtl/baud_rate_decode.sv
module baud_rate_decode
  import baud_clk_pkg::*;
#(
  parameter int DIV_2400 = 288,
  parameter int DIV_1200 = 576,
  parameter int DIV_600  = 1152,
  parameter int HW       = 10
) (
  input  logic          clk_sel_i,
  input  logic [1:0]    mod_kind_i,
  input  logic          mod_opt_i,
  output logic          tgt_div_o,
  output logic [HW-1:0] tgt_half_o
);

  localparam logic [HW-1:0] HALF_FAST = HW'(DIV_2400 / 2);
  localparam logic [HW-1:0] HALF_MID  = HW'(DIV_1200 / 2);
  localparam logic [HW-1:0] HALF_SLOW = HW'(DIV_600 / 2);

  always_comb begin
    tgt_div_o = clk_sel_i && is_phase_mod(mod_kind_i);
    case (mod_kind_i)
      MK_DPSK: tgt_half_o = mod_opt_i ? HALF_SLOW : HALF_MID;
      default: tgt_half_o = HALF_FAST;
    endcase
  end

endmodule

// File: rtl/baud_clk_divider.sv
module baud_clk_divider #(
  parameter int HW = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          tgt_div_i,
  input  logic [HW-1:0] tgt_half_i,
  output logic          xtal_en_o,
  output logic          div_o
);

  logic          xtal_en_q;
  logic          div_q;
  logic [HW-1:0] cnt_q;
  logic [HW-1:0] half_q;
  logic          phase_end;

  assign phase_end = (cnt_q == half_q - HW'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      xtal_en_q <= 1'b1;
      div_q     <= 1'b0;
      cnt_q     <= '0;
      half_q    <= '0;
    end else if (xtal_en_q) begin
      cnt_q <= '0;
      if (tgt_div_i) begin
        xtal_en_q <= 1'b0;
        half_q    <= tgt_half_i;
      end
    end else if (phase_end) begin
      cnt_q <= '0;
      if (div_q) begin
        div_q <= 1'b0;
      end else if (tgt_div_i) begin
        div_q  <= 1'b1;
        half_q <= tgt_half_i;
      end else begin
        xtal_en_q <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + HW'(1);
    end
  end

  assign xtal_en_o = xtal_en_q;
  assign div_o     = div_q;

endmodule

// File: rtl/baud_clk_gate.sv
module baud_clk_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic xtal_en_i,
  input  logic div_i,
  output logic gate_o,
  output logic clk_o
);

  logic gate_q;

  // Updated while the crystal is low, so opening or closing never cuts a pulse.
  always_ff @(negedge clk_i) begin
    if (rst_i) gate_q <= 1'b1;
    else       gate_q <= xtal_en_i;
  end

  assign gate_o = gate_q;
  assign clk_o  = (clk_i & gate_q) | div_i;

endmodule

// File: rtl/baud_clk_sel.sv
module baud_clk_sel #(
  parameter int DIV_2400 = 288,
  parameter int DIV_1200 = 576,
  parameter int DIV_600  = 1152
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       soft_rst_i,
  input  logic       clk_sel_i,
  input  logic [1:0] mod_kind_i,
  input  logic       mod_opt_i,
  output logic       clk_o
);

  localparam int HW = $clog2(DIV_600 / 2 + 1);

  logic          rst_any;
  logic          tgt_div;
  logic [HW-1:0] tgt_half;
  logic          xtal_en;
  logic          div_clk;
  logic          gate_en;

  assign rst_any = rst_i | soft_rst_i;

  baud_rate_decode #(
    .DIV_2400(DIV_2400), .DIV_1200(DIV_1200), .DIV_600(DIV_600), .HW(HW)
  ) dec_i (
    .clk_sel_i (clk_sel_i),
    .mod_kind_i(mod_kind_i),
    .mod_opt_i (mod_opt_i),
    .tgt_div_o (tgt_div),
    .tgt_half_o(tgt_half)
  );

  baud_clk_divider #(.HW(HW)) div_i (
    .clk_i     (clk_i),
    .rst_i     (rst_any),
    .tgt_div_i (tgt_div),
    .tgt_half_i(tgt_half),
    .xtal_en_o (xtal_en),
    .div_o     (div_clk)
  );

  baud_clk_gate gate_i (
    .clk_i    (clk_i),
    .rst_i    (rst_any),
    .xtal_en_i(xtal_en),
    .div_i    (div_clk),
    .gate_o   (gate_en),
    .clk_o    (clk_o)
  );

endmodule

// File: rtl/baud_clk_sel_chk.sv
module baud_clk_sel_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       soft_rst_i,
  input logic       clk_sel_i,
  input logic [1:0] mod_kind_i,
  input logic       xtal_en,
  input logic       div_clk,
  input logic       gate_en
);

  logic rst_any;
  assign rst_any = rst_i | soft_rst_i;

  assert_reset_to_xtal_R1: assert property (@(posedge clk_i)
    rst_any |=> (xtal_en && !div_clk));

  assert_sel_off_holds_R2: assert property (@(posedge clk_i) disable iff (rst_any)
    (xtal_en && !clk_sel_i) |=> xtal_en);

  assert_fsk_blocks_div_R3: assert property (@(posedge clk_i) disable iff (rst_any)
    (xtal_en && mod_kind_i[1]) |=> xtal_en);

  assert_leave_div_from_low_R8: assert property (@(posedge clk_i) disable iff (rst_any)
    $rose(xtal_en) |-> !$past(div_clk));

  assert_div_low_in_xtal_R9: assert property (@(posedge clk_i) disable iff (rst_any)
    xtal_en |-> !div_clk);

  assert_gate_closed_R9: assert property (@(posedge clk_i) disable iff (rst_any)
    (!xtal_en && !$past(xtal_en)) |-> !gate_en);

endmodule

bind baud_clk_sel baud_clk_sel_chk chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .soft_rst_i(soft_rst_i),
  .clk_sel_i (clk_sel_i),
  .mod_kind_i(mod_kind_i),
  .xtal_en   (xtal_en),
  .div_clk   (div_clk),
  .gate_en   (gate_en)
);

// File: tb/baud_clk_sel_tb_top.sv
`timescale 1ns/1ps
module baud_clk_sel_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  HALF_CLK   = CLK_PERIOD / 2;
  localparam int  D2400      = 288;
  localparam int  D1200      = 576;
  localparam int  D600       = 1152;
  localparam int  WDOG_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       soft_rst = 1'b0;
  logic       clk_sel = 1'b0;
  logic [1:0] mod_kind = 2'b00;
  logic       mod_opt = 1'b0;
  logic       clk_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(HALF_CLK) clk = ~clk;

  baud_clk_sel dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .soft_rst_i(soft_rst),
    .clk_sel_i (clk_sel),
    .mod_kind_i(mod_kind),
    .mod_opt_i (mod_opt),
    .clk_o     (clk_out)
  );

  // Pulse-width monitor
  logic mon_en = 1'b0;
  time  t_rise = 0, t_fall = 0;
  time  min_hi = 1000000000, min_lo = 1000000000;

  always @(posedge clk_out) begin
    if (mon_en && t_fall != 0 && ($time - t_fall) < min_lo) min_lo = $time - t_fall;
    t_rise = $time;
  end
  always @(negedge clk_out) begin
    if (mon_en && t_rise != 0 && ($time - t_rise) < min_hi) min_hi = $time - t_rise;
    t_fall = $time;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG_LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input time act, input time exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0t expected %0t", req, act, exp);
    end
  endtask

  task automatic measure(output time per, output time hi);
    time t0;
    @(posedge clk_out); t0 = $time;
    @(negedge clk_out); hi = $time - t0;
    @(posedge clk_out); per = $time - t0;
  endtask

  task automatic settle_measure(output time per, output time hi);
    time p, h;
    measure(p, h);
    measure(p, h);
    measure(per, hi);
  endtask

  task automatic set_mode(input logic sel, input logic [1:0] kind, input logic opt);
    @(negedge clk);
    clk_sel = sel; mod_kind = kind; mod_opt = opt;
  endtask

  task automatic test_reset;
    time p, h;
    settle_measure(p, h);
    check("R1 reset period", p, CLK_PERIOD);
    check("R1 reset high", h, HALF_CLK);
  endtask

  task automatic test_qam;
    time p, h;
    set_mode(1'b1, 2'b01, 1'b0);
    settle_measure(p, h);
    check("R4 qam period", p, D2400 * CLK_PERIOD);
    check("R7 qam high", h, D2400 * CLK_PERIOD / 2);
    set_mode(1'b1, 2'b01, 1'b1);
    settle_measure(p, h);
    check("R4 qam option ignored", p, D2400 * CLK_PERIOD);
  endtask

  task automatic test_dpsk;
    time p, h;
    set_mode(1'b1, 2'b00, 1'b0);
    settle_measure(p, h);
    check("R5 dpsk fast period", p, D1200 * CLK_PERIOD);
    check("R7 dpsk fast high", h, D1200 * CLK_PERIOD / 2);
    set_mode(1'b1, 2'b00, 1'b1);
    settle_measure(p, h);
    check("R6 dpsk slow period", p, D600 * CLK_PERIOD);
    check("R7 dpsk slow high", h, D600 * CLK_PERIOD / 2);
  endtask

  task automatic test_fsk_block;
    time p, h;
    set_mode(1'b1, 2'b10, 1'b0);
    settle_measure(p, h);
    check("R3 fsk 10 period", p, CLK_PERIOD);
    set_mode(1'b1, 2'b11, 1'b1);
    settle_measure(p, h);
    check("R3 fsk 11 period", p, CLK_PERIOD);
  endtask

  task automatic test_sel_off;
    time p, h;
    set_mode(1'b0, 2'b00, 1'b0);
    settle_measure(p, h);
    check("R2 select off period", p, CLK_PERIOD);
    check("R2 select off high", h, HALF_CLK);
  endtask

  task automatic test_ratio_change;
    time p, h, t0;
    set_mode(1'b1, 2'b01, 1'b0);
    settle_measure(p, h);
    @(posedge clk_out); t0 = $time;
    repeat (100) @(posedge clk);
    set_mode(1'b1, 2'b00, 1'b0);
    @(posedge clk_out);
    check("R8 period in progress keeps old ratio", $time - t0, D2400 * CLK_PERIOD);
    measure(p, h);
    check("R8 new ratio after boundary", p, D1200 * CLK_PERIOD);
  endtask

  task automatic test_return_xtal;
    time p, h, t0;
    @(posedge clk_out); t0 = $time;
    repeat (10) @(posedge clk);
    set_mode(1'b0, 2'b00, 1'b0);
    @(posedge clk_out);
    check("R8 crystal resumes after low boundary", $time - t0,
          D1200 * CLK_PERIOD + CLK_PERIOD);
    measure(p, h);
    check("R8 crystal period after return", p, CLK_PERIOD);
  endtask

  task automatic test_soft_reset;
    time p, h;
    set_mode(1'b1, 2'b01, 1'b0);
    settle_measure(p, h);
    @(posedge clk_out);
    repeat (30) @(posedge clk);
    @(negedge clk); soft_rst = 1'b1;
    settle_measure(p, h);
    check("R1 soft reset period", p, CLK_PERIOD);
    check("R1 soft reset high", h, HALF_CLK);
    @(negedge clk); soft_rst = 1'b0; clk_sel = 1'b0;
    settle_measure(p, h);
    check("R1 after soft reset release", p, CLK_PERIOD);
  endtask

  task automatic test_glitch;
    check("R9 min high pulse", (min_hi >= HALF_CLK) ? 1 : 0, 1);
    check("R9 min low pulse", (min_lo >= HALF_CLK) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    mon_en = 1'b1;
    test_reset();
    test_qam();
    test_dpsk();
    test_fsk_block();
    test_sel_off();
    test_ratio_change();
    test_return_xtal();
    test_soft_reset();
    test_glitch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule